// File: doc/BRIEF.md
# Leakage-Corner Body-Bias Selector

This block decides which of three body-bias levels a memory array should run at, using one reading of the whole array's leakage. Summing the current of every cell averages out random cell-to-cell spread, so the reading shows mainly the die-wide threshold shift. An external monitor turns that current into a voltage. Two comparators check that voltage against a lower and an upper reference, which gives three leakage regions.

A calibration starts with a one-cycle request. The controller closes the monitor bypass, waits a programmable settle time, and then samples both comparator bits for N cycles, with N odd. Each bit passes through a two-flop synchronizer before it is sampled. A majority vote is taken on each bit separately. The two majority bits then select a level:
- Low leakage is the high-threshold corner. It gets forward bias, which reduces access and write failures.
- High leakage is the low-threshold corner. It gets reverse bias, which reduces read and hold failures.
- Anything between the two references gets zero bias.

The one-hot bias output changes only when a calibration finishes, and that cycle is marked by a done pulse. If the two majority bits contradict each other, the result is flagged as an error and the bias is left unchanged.

Top module: `leak_bias_ctrl`

## Requirements
- R1: During and after reset, `bias_sel` is 3'b010 (zero bias), and `bypass_en`, `cal_done` and `cal_err` are all 0.
- R2: `bypass_en` is 1 from the cycle after an accepted `cal_req` up to and including the cycle of the last sample. It is 0 in the cycle in which `cal_done` is 1.
- R3: After the request is accepted, the controller waits `cfg_settle`+1 cycles in settle before the first sample. `cal_done` is therefore seen `cfg_settle`+N+2 cycles after the cycle in which `cal_req` was presented.
- R4: Each comparator bit is delayed by two flops. A sample taken at a clock edge uses the input level that was present two edges earlier.
- R5: N equals `cfg_votes` with bit 0 forced to 1, so 0 gives 1 and 4 gives 5. Each comparator bit is resolved by strict majority over N consecutive samples.
- R6: The majority bits select the level as follows. If `cmp_hi` holds the majority, the result is reverse (`bias_sel`=3'b100). Otherwise, if `cmp_lo` does not hold the majority, the result is forward (3'b001). Otherwise the result is zero (3'b010).
- R7: A majority `cmp_hi` together with a minority `cmp_lo` is invalid. In that case `cal_err` becomes 1 with `cal_done` and `bias_sel` keeps its previous value. The next valid completion clears `cal_err`.
- R8: `cal_done` is a one-cycle pulse, and `bias_sel` changes only in a cycle where `cal_done` is 1.
- R9: A `cal_req` that arrives while a calibration is running is ignored. It neither restarts the calibration nor produces an extra done pulse.
- R10: `bias_sel` always has exactly one bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cal_req | input | 1 | Calibration request; accepted only while idle |
| cfg_settle | input | SETTLE_W (8) | Settle wait in cycles, minus one |
| cfg_votes | input | VOTE_W (4) | Vote count; bit 0 is forced to 1 |
| cmp_lo | input | 1 | Asynchronous comparator: monitor above lower reference |
| cmp_hi | input | 1 | Asynchronous comparator: monitor above upper reference |
| bypass_en | output | 1 | Monitor bypass switch closed |
| bias_sel | output | 3 | One-hot bias: bit0 forward, bit1 zero, bit2 reverse |
| cal_done | output | 1 | One-cycle completion pulse |
| cal_err | output | 1 | Last calibration gave contradictory comparator majorities |

## Verification
A wrong settle or vote count inside the controller shows up in the first calibration, as a `cal_done` pulse that is early or late by a whole number of cycles. A stuck bypass shows up as `bypass_en` still set during the done cycle. A tally or synchronizer fault changes `bias_sel` only when the vote is close or an input moves near the sampling window. For that reason the stimulus includes periodic comparator noise and one input change placed exactly two edges before a single-vote sample. A per-cycle behavioural model catches any difference on every port in the cycle it first appears.

// File: rtl/bbsel_pkg.sv
package bbsel_pkg;

    localparam int BIAS_W = 3;

    typedef enum logic [1:0] {
        LVL_ZERO = 2'd0,
        LVL_FWD  = 2'd1,
        LVL_REV  = 2'd2
    } bias_lvl_t;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETTLE = 2'd1,
        ST_SAMPLE = 2'd2
    } seq_st_t;

    typedef struct packed {
        logic hi;
        logic lo;
    } cmp_pair_t;

    typedef struct packed {
        bias_lvl_t lvl;
        logic      bad;
    } verdict_t;

    // Classify the two majority bits into a bias level (R6, R7)
    function automatic verdict_t judge(cmp_pair_t m);
        verdict_t v;
        v.bad = m.hi & ~m.lo;
        if (m.hi)       v.lvl = LVL_REV;
        else if (!m.lo) v.lvl = LVL_FWD;
        else            v.lvl = LVL_ZERO;
        return v;
    endfunction

    // bit0 forward, bit1 zero, bit2 reverse
    function automatic logic [BIAS_W-1:0] to_onehot(bias_lvl_t l);
        case (l)
            LVL_FWD: return 3'b001;
            LVL_REV: return 3'b100;
            default: return 3'b010;
        endcase
    endfunction

endpackage

// File: rtl/bb_sync.sv
module bb_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            logic [STAGES-1:0] chain;
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= {chain[STAGES-2:0], d[i]};
            end
            assign q[i] = chain[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/bb_tally.sv
module bb_tally #(
    parameter int CH    = 2,
    parameter int CNT_W = 4
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      clr,
    input  logic                      en,
    input  logic [CH-1:0]             bits,
    output logic [CH-1:0][CNT_W-1:0]  cnt
);
    generate
        for (genvar i = 0; i < CH; i++) begin : g_ch
            logic [CNT_W-1:0] c_q;
            always_ff @(posedge clk) begin
                if (rst || clr)       c_q <= '0;
                else if (en && bits[i]) c_q <= c_q + CNT_W'(1);
            end
            assign cnt[i] = c_q;
        end
    endgenerate
endmodule

// File: rtl/bb_seq.sv
module bb_seq
    import bbsel_pkg::*;
#(
    parameter int SETTLE_W = 8,
    parameter int VOTE_W   = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cal_req,
    input  logic [SETTLE_W-1:0] cfg_settle,
    input  logic [VOTE_W-1:0]   cfg_votes,
    output logic                accept,
    output logic                sampling,
    output logic                last,
    output logic                bypass,
    output logic [VOTE_W-1:0]   n_votes
);
    seq_st_t             st;
    logic [SETTLE_W-1:0] settle_cnt;
    logic [VOTE_W-1:0]   idx;

    assign accept   = (st == ST_IDLE) && cal_req;
    assign sampling = (st == ST_SAMPLE);
    assign last     = sampling && (idx == n_votes - VOTE_W'(1));
    assign bypass   = (st != ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= ST_IDLE;
            settle_cnt <= '0;
            idx        <= '0;
            n_votes    <= VOTE_W'(1);
        end else begin
            case (st)
                ST_IDLE: if (cal_req) begin
                    st         <= ST_SETTLE;
                    settle_cnt <= cfg_settle;
                    n_votes    <= cfg_votes | VOTE_W'(1);
                end
                ST_SETTLE: begin
                    if (settle_cnt == '0) begin
                        st  <= ST_SAMPLE;
                        idx <= '0;
                    end else begin
                        settle_cnt <= settle_cnt - SETTLE_W'(1);
                    end
                end
                ST_SAMPLE: begin
                    if (last) st  <= ST_IDLE;
                    else      idx <= idx + VOTE_W'(1);
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assert_idx_bound_R5: assert property (@(posedge clk) disable iff (rst)
        sampling |-> (idx < n_votes));

    assert_settle_countdown_R3: assert property (@(posedge clk) disable iff (rst)
        (st == ST_SETTLE && settle_cnt != '0) |=>
            (st == ST_SETTLE && settle_cnt == $past(settle_cnt) - SETTLE_W'(1)));

    assert_busy_ignore_R9: assert property (@(posedge clk) disable iff (rst)
        (st == ST_SAMPLE && !last) |=> (st == ST_SAMPLE));
endmodule

// File: rtl/leak_bias_ctrl.sv
module leak_bias_ctrl
    import bbsel_pkg::*;
#(
    parameter int SETTLE_W = 8,
    parameter int VOTE_W   = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cal_req,
    input  logic [SETTLE_W-1:0] cfg_settle,
    input  logic [VOTE_W-1:0]   cfg_votes,
    input  logic                cmp_lo,
    input  logic                cmp_hi,
    output logic                bypass_en,
    output logic [2:0]          bias_sel,
    output logic                cal_done,
    output logic                cal_err
);
    localparam int CH = 2;

    cmp_pair_t                    raw_pair, syn_pair, maj_pair;
    logic [CH-1:0][VOTE_W-1:0]    tally;
    logic                         accept, sampling, last;
    logic [VOTE_W-1:0]            n_votes;
    verdict_t                     verdict;
    logic [BIAS_W-1:0]            bias_q;
    logic                         done_q, err_q;

    assign raw_pair.lo = cmp_lo;
    assign raw_pair.hi = cmp_hi;

    bb_sync #(.WIDTH(CH), .STAGES(2)) u_sync (
        .clk (clk), .rst (rst), .d (raw_pair), .q (syn_pair)
    );

    bb_seq #(.SETTLE_W(SETTLE_W), .VOTE_W(VOTE_W)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .cal_req    (cal_req),
        .cfg_settle (cfg_settle),
        .cfg_votes  (cfg_votes),
        .accept     (accept),
        .sampling   (sampling),
        .last       (last),
        .bypass     (bypass_en),
        .n_votes    (n_votes)
    );

    bb_tally #(.CH(CH), .CNT_W(VOTE_W)) u_tally (
        .clk  (clk),
        .rst  (rst),
        .clr  (accept),
        .en   (sampling),
        .bits (syn_pair),
        .cnt  (tally)
    );

    // strict majority including the sample taken this cycle
    function automatic logic majority(logic [VOTE_W-1:0] c, logic b, logic [VOTE_W-1:0] n);
        return (2 * (int'(c) + int'(b))) > int'(n);
    endfunction

    assign maj_pair.lo = majority(tally[0], syn_pair.lo, n_votes);
    assign maj_pair.hi = majority(tally[1], syn_pair.hi, n_votes);
    assign verdict     = judge(maj_pair);

    always_ff @(posedge clk) begin
        if (rst) begin
            bias_q <= to_onehot(LVL_ZERO);
            done_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            done_q <= last;
            if (last) begin
                err_q <= verdict.bad;
                if (!verdict.bad) bias_q <= to_onehot(verdict.lvl);
            end
        end
    end

    assign bias_sel = bias_q;
    assign cal_done = done_q;
    assign cal_err  = err_q;

    assert_bias_onehot_R10: assert property (@(posedge clk) disable iff (rst)
        $countones(bias_sel) == 1);

    assert_bias_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !cal_done |-> $stable(bias_sel));

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        cal_done |=> !cal_done);

    assert_bypass_open_at_done_R2: assert property (@(posedge clk) disable iff (rst)
        cal_done |-> !bypass_en);

    assert_err_with_done_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(cal_err) |-> cal_done);
endmodule

// File: tb/test_leak_bias_ctrl.sv
`timescale 1ns/1ps
module test_leak_bias_ctrl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cal_req = 1'b0;
    logic [7:0] cfg_settle = 8'd0;
    logic [3:0] cfg_votes = 4'd1;
    logic       lo_base = 1'b0, hi_base = 1'b0;
    int         noise_mode = 0;
    int         noise_ph = 0;
    logic       cmp_lo, cmp_hi;
    logic       bypass_en, cal_done, cal_err;
    logic [2:0] bias_sel;

    int checks = 0, fails = 0, cycles = 0;

    always #5 clk = ~clk;

    // noise: mode 1 -> hi 1-of-3, mode 2 -> hi 2-of-3
    assign cmp_lo = lo_base;
    assign cmp_hi = (noise_mode == 1) ? (noise_ph == 0) :
                    (noise_mode == 2) ? (noise_ph != 0) : hi_base;

    always @(negedge clk) noise_ph <= (noise_ph + 1) % 3;

    leak_bias_ctrl i_leak_bias_ctrl (
        .clk(clk), .rst(rst), .cal_req(cal_req), .cfg_settle(cfg_settle),
        .cfg_votes(cfg_votes), .cmp_lo(cmp_lo), .cmp_hi(cmp_hi),
        .bypass_en(bypass_en), .bias_sel(bias_sel), .cal_done(cal_done),
        .cal_err(cal_err)
    );

    // behavioural reference model
    logic m_s1lo, m_s1hi, m_s2lo, m_s2hi;
    int   m_ph, m_rem, m_n, m_clo, m_chi, m_k;
    logic [2:0] m_bias;
    logic m_done, m_err;

    always @(posedge clk) begin
        if (rst) begin
            m_s1lo = 0; m_s1hi = 0; m_s2lo = 0; m_s2hi = 0;
            m_ph = 0; m_rem = 0; m_n = 1; m_clo = 0; m_chi = 0; m_k = 0;
            m_bias = 3'b010; m_done = 0; m_err = 0;
        end else begin
            logic slo, shi, lm, hm;
            slo = m_s2lo; shi = m_s2hi;
            m_s2lo = m_s1lo; m_s2hi = m_s1hi;
            m_s1lo = cmp_lo; m_s1hi = cmp_hi;
            m_done = 0;
            if (m_ph == 0) begin
                if (cal_req) begin
                    m_ph = 1; m_rem = int'(cfg_settle); m_n = int'(cfg_votes) | 1;
                    m_clo = 0; m_chi = 0; m_k = 0;
                end
            end else if (m_ph == 1) begin
                if (m_rem == 0) m_ph = 2; else m_rem = m_rem - 1;
            end else begin
                m_clo += int'(slo); m_chi += int'(shi); m_k++;
                if (m_k == m_n) begin
                    lm = (2 * m_clo) > m_n; hm = (2 * m_chi) > m_n;
                    m_done = 1; m_ph = 0;
                    if (hm && !lm) m_err = 1;
                    else begin
                        m_err = 0;
                        m_bias = hm ? 3'b100 : (!lm ? 3'b001 : 3'b010);
                    end
                end
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: %s", req, what);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        cycles++;
        if (cycles > 1) begin
            check(bypass_en == (m_ph != 0), "R2",
                  $sformatf("bypass_en act=%0b exp=%0b", bypass_en, m_ph != 0));
            check(bias_sel == m_bias, "R6",
                  $sformatf("bias_sel act=%b exp=%b", bias_sel, m_bias));
            check(cal_done == m_done, "R8",
                  $sformatf("cal_done act=%0b exp=%0b", cal_done, m_done));
            check(cal_err == m_err, "R7",
                  $sformatf("cal_err act=%0b exp=%0b", cal_err, m_err));
        end
        if (cycles > 20000) begin
            fails++;
            $display("FAIL watchdog: act=timeout exp=finish");
            $display("[TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end

    // one calibration; checks done timing, bypass span and result
    task automatic calib(input int s, input int v, input int ek,
                         input logic [2:0] eb, input logic ee, input string req,
                         input bit poke, input int flip_at,
                         input logic flo, input logic fhi);
        int k = 0, byp = 0;
        bit got = 0;
        cfg_settle = 8'(s); cfg_votes = 4'(v); cal_req = 1;
        while (k < 300 && !got) begin
            @(negedge clk);
            k++;
            if (k == 1) cal_req = 0;
            if (poke && k == 2) cal_req = 1;
            if (poke && k == 3) cal_req = 0;
            if (k == flip_at) begin lo_base = flo; hi_base = fhi; end
            if (cal_done) got = 1;
            else if (bypass_en) byp++;
        end
        check(k == ek, "R3", $sformatf("done after act=%0d exp=%0d cycles", k, ek));
        check(byp == ek - 1, "R2", $sformatf("bypass cycles act=%0d exp=%0d", byp, ek - 1));
        check(bias_sel == eb, req, $sformatf("bias act=%b exp=%b", bias_sel, eb));
        check(cal_err == ee, req, $sformatf("err act=%0b exp=%0b", cal_err, ee));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(bias_sel == 3'b010 && !bypass_en && !cal_done && !cal_err, "R1",
              $sformatf("reset outs act=%b%0b%0b%0b exp=010000", bias_sel, bypass_en, cal_done, cal_err));
        rst = 0;
        repeat (4) @(negedge clk);

        // R6 forward corner: both comparators low
        lo_base = 0; hi_base = 0; repeat (3) @(negedge clk);
        calib(3, 5, 3+5+2, 3'b001, 0, "R6", 0, 0, 0, 0);
        // R6 reverse corner, no settle
        lo_base = 1; hi_base = 1; repeat (3) @(negedge clk);
        calib(0, 3, 0+3+2, 3'b100, 0, "R6", 0, 0, 0, 0);
        // R5: votes 0 -> N=1; nominal
        lo_base = 1; hi_base = 0; repeat (3) @(negedge clk);
        calib(2, 0, 2+1+2, 3'b010, 0, "R5", 0, 0, 0, 0);
        // R7: invalid pair keeps bias, raises err
        lo_base = 0; hi_base = 1; repeat (3) @(negedge clk);
        calib(1, 3, 1+3+2, 3'b010, 1, "R7", 0, 0, 0, 0);
        // R7: valid run clears err
        lo_base = 1; hi_base = 1; repeat (3) @(negedge clk);
        calib(1, 3, 1+3+2, 3'b100, 0, "R7", 0, 0, 0, 0);
        // R5: votes 4 -> N=5
        lo_base = 0; hi_base = 0; repeat (3) @(negedge clk);
        calib(4, 4, 4+5+2, 3'b001, 0, "R5", 0, 0, 0, 0);
        // R5 majority under noise: hi 1-of-3 -> zero, 2-of-3 -> reverse
        lo_base = 1; noise_mode = 1; repeat (3) @(negedge clk);
        calib(2, 5, 2+5+2, 3'b010, 0, "R5", 0, 0, 0, 0);
        noise_mode = 2; repeat (3) @(negedge clk);
        calib(2, 5, 2+5+2, 3'b100, 0, "R5", 0, 0, 0, 0);
        noise_mode = 0;
        // R9: request during busy ignored
        lo_base = 0; hi_base = 0; repeat (3) @(negedge clk);
        calib(5, 3, 5+3+2, 3'b001, 0, "R9", 1, 0, 0, 0);
        begin
            bit extra = 0;
            repeat (12) begin @(negedge clk); if (cal_done || bypass_en) extra = 1; end
            check(!extra, "R9", $sformatf("extra activity act=%0b exp=0", extra));
        end
        // R4: single sample sees level from two edges earlier (levels high, then dropped)
        lo_base = 1; hi_base = 1; repeat (4) @(negedge clk);
        calib(2, 1, 2+1+2, 3'b100, 0, "R4", 0, 3, 0, 0);
        // R4: opposite direction
        repeat (4) @(negedge clk);
        calib(2, 1, 2+1+2, 3'b001, 0, "R4", 0, 3, 1, 1);
        // R1/R10: reset mid-run restores zero bias
        lo_base = 0; hi_base = 0;
        cfg_settle = 8'd6; cal_req = 1; @(negedge clk); cal_req = 0;
        repeat (3) @(negedge clk);
        rst = 1; @(negedge clk); @(negedge clk);
        check(bias_sel == 3'b010 && !bypass_en && !cal_err, "R1",
              $sformatf("reset mid-run act=%b%0b exp=0100", bias_sel, bypass_en));
        check($countones(bias_sel) == 1, "R10", $sformatf("onehot act=%b exp=one bit", bias_sel));
        rst = 0;
        repeat (5) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end
endmodule